// File: doc/BRIEF.md
# External Interrupt Sensitivity Controller

This block turns a bank of general-purpose input pins into four independent external interrupt sources. Each source owns a contiguous group of pins; the group sizes are parameters. Within a group, a pin contributes only when its direction bit marks it as an input and its option bit enables it for interrupts. The enabled pins of a group are merged. An edge on any of them is an edge on the source. A level condition holds if any enabled pin sits at the active level.

A single 10-bit sensitivity register selects, per source, falling edge, rising edge, both edges, or a combined edge-plus-level mode. Two polarity bits, each shared by a pair of sources, can turn the combined mode into rising edge plus high level. This only works on the two sources able to use it. The CPU's current interrupt-mask level gates register writes: a write lands only when the CPU is at the fully masked level. Edge events set a sticky pending flag per source. The flag stays set until that source's acknowledge input or a register write that changes the source's configuration. In the combined modes, the pending output also stays high while the active level persists.

Top module: `xirq_sense_ctrl`

## Requirements
- R1: After reset the register reads 0 and all four pending outputs are 0 (the synchronizer stages reset to 1, so pins held high cause no event).
- R2: A write on `cfg_wr` is accepted only when `cpu_lvl` is 2'b11; `cfg_rdata` then shows the written value from the next cycle. A write at any other level leaves `cfg_rdata` unchanged.
- R3: Register layout: bits [2s+1:2s] hold the mode of source s (00 fall+low, 01 rise, 10 fall, 11 both edges); bit 8 is the polarity bit for sources 0 and 1; bit 9 is the polarity bit for sources 2 and 3.
- R4: A pin takes part in its source only when its `pin_dir` bit is 0 (input) and its `pin_opt` bit is 1. Other pins cause no event and no level condition.
- R5: In mode 10, a falling pin value applied before clock edge k sets the source's pending output after edge k+2. The output stays set after the pin returns high.
- R6: Mode 01 reacts only to rising edges. Mode 11 reacts to both rising and falling edges. Both use the same two-cycle latency as R5.
- R7: In mode 00 with polarity 0, a falling edge sets the sticky flag. In addition, pending is high from edge k+1 for as long as any enabled pin is low, even after acknowledge.
- R8: On sources 0 and 2, mode 00 with polarity 1 means rising edge plus high level (any enabled pin high). On sources 1 and 3 the polarity bit has no effect on detection.
- R9: `irq_ack[s]` clears the sticky flag at the next edge. If an acknowledge and a new edge meet on the same edge, the acknowledge wins.
- R10: An accepted write that changes a source's mode field or its polarity bit clears that source's sticky flag. An accepted write that changes neither leaves the flag set.
- R11: Sources 0 to 3 take pin groups of `GW0`..`GW3` pins (defaults 3, 1, 4, 1) packed from bit 0 upward. An edge on any enabled pin of a group counts for its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Raw pin values, synchronized inside |
| pin_dir | input | NPIN | Per-pin direction, 1 = output |
| pin_opt | input | NPIN | Per-pin interrupt enable |
| cpu_lvl | input | 2 | CPU interrupt-mask level; 2'b11 unlocks writes |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 10 | Register write data |
| cfg_rdata | output | 10 | Current register contents |
| irq_ack | input | 4 | Per-source acknowledge |
| irq_pend | output | 4 | Per-source pending interrupt |

## Verification
Results fall due at different times. A register write shows on `cfg_rdata`, and its clearing effect shows on `irq_pend`, one cycle after the write edge. A level condition reaches `irq_pend` two edges after the pin change. An edge-set flag appears one edge later, after three. Directed cases drive inputs at the falling clock edge and step exactly that many edges before sampling. They also sample the cycle before an edge result is due, to confirm it is not yet present. In the random phase, a cycle model in the bench mirrors the synchronizer and pending flags from the requirements and is compared at every falling edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int unsigned NUM_SRC   = 4;
    localparam int unsigned FLD_W     = 2;
    localparam int unsigned POL_BASE  = NUM_SRC * FLD_W;
    localparam int unsigned CFG_W     = POL_BASE + NUM_SRC / 2;
    localparam int unsigned LVL_W     = 2;
    localparam logic [LVL_W-1:0] LVL_MASKED = 2'b11;

    typedef enum logic [FLD_W-1:0] {
        MD_FALL_LOW = 2'b00,
        MD_RISE     = 2'b01,
        MD_FALL     = 2'b10,
        MD_BOTH     = 2'b11
    } sense_mode_e;

    typedef struct packed {
        logic fall;
        logic rise;
        logic low;
        logic high;
    } sense_sel_t;

    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_HELD = 1'b1
    } pend_state_e;

    function automatic sense_sel_t decode_sense(sense_mode_e md, logic pol, logic hi_capable);
        sense_sel_t s;
        s = '0;
        unique case (md)
            MD_FALL_LOW: begin
                if (pol && hi_capable) begin
                    s.rise = 1'b1;
                    s.high = 1'b1;
                end else begin
                    s.fall = 1'b1;
                    s.low  = 1'b1;
                end
            end
            MD_RISE: s.rise = 1'b1;
            MD_FALL: s.fall = 1'b1;
            MD_BOTH: begin
                s.rise = 1'b1;
                s.fall = 1'b1;
            end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/xirq_pin_sync.sv
module xirq_pin_sync #(
    parameter int unsigned W       = 9,
    parameter logic        RST_LVL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {W{RST_LVL}};
            sync_q <= {W{RST_LVL}};
            last_q <= {W{RST_LVL}};
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign cur = sync_q;
    assign prv = last_q;

endmodule

// File: rtl/xirq_src_merge.sv
module xirq_src_merge #(
    parameter int unsigned W = 3
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prv,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] opt,
    output logic         fall_any,
    output logic         rise_any,
    output logic         low_any,
    output logic         high_any
);

    logic [W-1:0] live;

    always_comb begin
        live     = ~dir & opt;
        fall_any = |(live & prv & ~cur);
        rise_any = |(live & ~prv & cur);
        low_any  = |(live & ~cur);
        high_any = |(live & cur);
    end

endmodule

// File: rtl/xirq_cfg_reg.sv
module xirq_cfg_reg
    import xirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] cpu_lvl,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic [NUM_SRC-1:0] src_clr
);

    logic accept;

    assign accept = wr && (cpu_lvl == LVL_MASKED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= wdata;
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
        localparam int unsigned FLO = s * FLD_W;
        localparam int unsigned PIX = POL_BASE + s / 2;
        logic changed;
        assign changed = (wdata[FLO +: FLD_W] != cfg_q[FLO +: FLD_W])
                       || (wdata[PIX] != cfg_q[PIX]);
        assign src_clr[s] = accept && changed;
    end

endmodule

// File: rtl/xirq_pend_fsm.sv
module xirq_pend_fsm
    import xirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sense_sel_t sel,
    input  logic       fall_any,
    input  logic       rise_any,
    input  logic       low_any,
    input  logic       high_any,
    input  logic       ack,
    input  logic       clr,
    output logic       pend
);

    pend_state_e state_q;
    pend_state_e state_d;
    logic        edge_hit;
    logic        drop;

    assign edge_hit = (sel.fall && fall_any) || (sel.rise && rise_any);
    assign drop     = ack || clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (edge_hit && !drop) state_d = PS_HELD;
            PS_HELD: if (drop)              state_d = PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q == PS_HELD)
             || (sel.low && low_any)
             || (sel.high && high_any);
    end

endmodule

// File: rtl/xirq_sense_ctrl.sv
module xirq_sense_ctrl
    import xirq_pkg::*;
#(
    parameter int unsigned GW0 = 3,
    parameter int unsigned GW1 = 1,
    parameter int unsigned GW2 = 4,
    parameter int unsigned GW3 = 1,
    localparam int unsigned NPIN = GW0 + GW1 + GW2 + GW3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPIN-1:0]    pin_in,
    input  logic [NPIN-1:0]    pin_dir,
    input  logic [NPIN-1:0]    pin_opt,
    input  logic [LVL_W-1:0]   cpu_lvl,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [CFG_W-1:0]   cfg_rdata,
    input  logic [NUM_SRC-1:0] irq_ack,
    output logic [NUM_SRC-1:0] irq_pend
);

    logic [NPIN-1:0]    pin_cur;
    logic [NPIN-1:0]    pin_prv;
    logic [CFG_W-1:0]   cfg_q;
    logic [NUM_SRC-1:0] src_clr;

    xirq_pin_sync #(.W(NPIN), .RST_LVL(1'b1)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .raw (pin_in),
        .cur (pin_cur),
        .prv (pin_prv)
    );

    xirq_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_lvl (cpu_lvl),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .cfg_q   (cfg_q),
        .src_clr (src_clr)
    );

    assign cfg_rdata = cfg_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int unsigned GW  = (s == 0) ? GW0 : (s == 1) ? GW1 : (s == 2) ? GW2 : GW3;
        localparam int unsigned OFS = (s == 0) ? 0
                                    : (s == 1) ? GW0
                                    : (s == 2) ? GW0 + GW1
                                    : GW0 + GW1 + GW2;
        localparam logic HI_OK = ((s % 2) == 0);

        logic       fall_any, rise_any, low_any, high_any;
        sense_sel_t sel;

        assign sel = decode_sense(sense_mode_e'(cfg_q[s*FLD_W +: FLD_W]),
                                  cfg_q[POL_BASE + s/2], HI_OK);

        xirq_src_merge #(.W(GW)) u_merge (
            .cur      (pin_cur[OFS +: GW]),
            .prv      (pin_prv[OFS +: GW]),
            .dir      (pin_dir[OFS +: GW]),
            .opt      (pin_opt[OFS +: GW]),
            .fall_any (fall_any),
            .rise_any (rise_any),
            .low_any  (low_any),
            .high_any (high_any)
        );

        xirq_pend_fsm u_pend (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (sel),
            .fall_any (fall_any),
            .rise_any (rise_any),
            .low_any  (low_any),
            .high_any (high_any),
            .ack      (irq_ack[s]),
            .clr      (src_clr[s]),
            .pend     (irq_pend[s])
        );
    end

endmodule

// File: rtl/xirq_sense_chk.sv
module xirq_sense_chk
    import xirq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [LVL_W-1:0]   cpu_lvl,
    input logic               cfg_wr,
    input logic [CFG_W-1:0]   cfg_wdata,
    input logic [CFG_W-1:0]   cfg_rdata,
    input logic [NUM_SRC-1:0] irq_ack,
    input logic [NUM_SRC-1:0] irq_pend
);

    assert_locked_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cpu_lvl != LVL_MASKED) |=> $stable(cfg_rdata));

    assert_open_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cpu_lvl == LVL_MASKED) |=> (cfg_rdata == $past(cfg_wdata)));

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int unsigned FLO = s * FLD_W;
        localparam int unsigned PIX = POL_BASE + s / 2;

        // R10: config change into a pure edge mode leaves nothing pending
        assert_change_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr && cpu_lvl == LVL_MASKED
             && ((cfg_wdata[FLO +: FLD_W] != cfg_rdata[FLO +: FLD_W]) || (cfg_wdata[PIX] != cfg_rdata[PIX]))
             && cfg_wdata[FLO +: FLD_W] != 2'b00)
            |=> !irq_pend[s]);

        // R9: acknowledge in a pure edge mode drops pending, even against a new edge
        assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_ack[s] && !cfg_wr && cfg_rdata[FLO +: FLD_W] != 2'b00) |=> !irq_pend[s]);
    end

endmodule

bind xirq_sense_ctrl xirq_sense_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_lvl   (cpu_lvl),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .irq_ack   (irq_ack),
    .irq_pend  (irq_pend)
);

// File: tb/tb_xirq_sense_ctrl.sv
module tb_xirq_sense_ctrl;
    import xirq_pkg::*;

    localparam int unsigned NPIN = 9;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NPIN-1:0]    pin_in = '1;
    logic [NPIN-1:0]    pin_dir = '0;
    logic [NPIN-1:0]    pin_opt = '1;
    logic [1:0]         cpu_lvl = 2'b11;
    logic               cfg_wr = 1'b0;
    logic [9:0]         cfg_wdata = '0;
    logic [9:0]         cfg_rdata;
    logic [3:0]         irq_ack = '0;
    logic [3:0]         irq_pend;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xirq_sense_ctrl dut (
        .clk (clk), .rst_n (rst_n), .pin_in (pin_in), .pin_dir (pin_dir),
        .pin_opt (pin_opt), .cpu_lvl (cpu_lvl), .cfg_wr (cfg_wr),
        .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .irq_ack (irq_ack),
        .irq_pend (irq_pend)
    );

    // ---------------- reference model built from the requirements ----------
    logic [NPIN-1:0] m_s1, m_s2, m_pv;
    logic [9:0]      m_cfg;
    logic [3:0]      m_st;

    function automatic logic [NPIN-1:0] grp_mask(int s);
        int lo, w;
        logic [NPIN-1:0] m;
        lo = (s == 0) ? 0 : (s == 1) ? 3 : (s == 2) ? 4 : 8;
        w  = (s == 0) ? 3 : (s == 1) ? 1 : (s == 2) ? 4 : 1;
        m  = '0;
        for (int i = 0; i < w; i++) m[lo + i] = 1'b1;
        return m;
    endfunction

    // returns {fall, rise, low, high}
    function automatic logic [3:0] sel_of(int s, logic [9:0] c);
        logic [1:0] f;
        logic p;
        f = c[2*s +: 2];
        p = c[8 + s/2];
        case (f)
            2'b01:   return 4'b0100;
            2'b10:   return 4'b1000;
            2'b11:   return 4'b1100;
            default: return (p && (s % 2 == 0)) ? 4'b0101 : 4'b1010;
        endcase
    endfunction

    function automatic logic [3:0] model_next();
        logic [3:0] n;
        logic [NPIN-1:0] en;
        logic [3:0] sl;
        logic ev, acc, chg;
        acc = cfg_wr && cpu_lvl == 2'b11;
        for (int s = 0; s < 4; s++) begin
            en  = grp_mask(s) & ~pin_dir & pin_opt;
            sl  = sel_of(s, m_cfg);
            ev  = (sl[3] && |(en & m_pv & ~m_s2)) || (sl[2] && |(en & ~m_pv & m_s2));
            chg = (cfg_wdata[2*s +: 2] != m_cfg[2*s +: 2]) || (cfg_wdata[8 + s/2] != m_cfg[8 + s/2]);
            n[s] = (irq_ack[s] || (acc && chg)) ? 1'b0 : (ev ? 1'b1 : m_st[s]);
        end
        return n;
    endfunction

    function automatic logic [3:0] model_pend();
        logic [3:0] p;
        logic [NPIN-1:0] en;
        logic [3:0] sl;
        for (int s = 0; s < 4; s++) begin
            en = grp_mask(s) & ~pin_dir & pin_opt;
            sl = sel_of(s, m_cfg);
            p[s] = m_st[s] || (sl[1] && |(en & ~m_s2)) || (sl[0] && |(en & m_s2));
        end
        return p;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '1; m_s2 <= '1; m_pv <= '1; m_cfg <= '0; m_st <= '0;
        end else begin
            m_st <= model_next();
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            m_pv <= m_s2;
            if (cfg_wr && cpu_lvl == 2'b11) m_cfg <= cfg_wdata;
        end
    end

    // ---------------- helpers ----------------------------------------------
    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [1:0] lvl, logic [9:0] d);
        cpu_lvl = lvl; cfg_wdata = d; cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0; cpu_lvl = 2'b11;
    endtask

    task automatic pulse_ack(logic [3:0] a);
        irq_ack = a;
        step();
        irq_ack = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired before the run ended");
        finish_run();
    end

    // ---------------- stimulus ---------------------------------------------
    initial begin
        void'($urandom(32'd20240611));
        step(3);
        rst_n = 1'b1;
        step();

        // R1: reset state
        check("R1 cfg after reset", cfg_rdata, 10'h000);
        check("R1 pend after reset", irq_pend, 4'h0);

        // R2: locked write ignored, open write lands
        wr_cfg(2'b10, 10'h3FF);
        check("R2 locked write ignored", cfg_rdata, 10'h000);
        wr_cfg(2'b01, 10'h155);
        check("R2 locked write ignored lvl1", cfg_rdata, 10'h000);
        wr_cfg(2'b11, 10'h0AA);               // R3: every source mode 10
        check("R2 open write lands", cfg_rdata, 10'h0AA);

        // R5: falling edge on middle pin of group 0
        pin_in[1] = 1'b0;
        step(2);
        check("R5 not yet pending at k+1", irq_pend[0], 1'b0);
        step();
        check("R5 pending at k+2", irq_pend[0], 1'b1);
        pin_in[1] = 1'b1;
        step(3);
        check("R5 sticky after pin returns", irq_pend[0], 1'b1);
        pulse_ack(4'b0001);
        check("R9 ack clears", irq_pend[0], 1'b0);

        // R4: disabled pins do nothing
        pin_opt[5] = 1'b0; pin_in[5] = 1'b0;
        step(3);
        check("R4 option-off pin ignored", irq_pend[2], 1'b0);
        pin_in[5] = 1'b1; step(3); pin_opt[5] = 1'b1;
        pin_dir[6] = 1'b1; pin_in[6] = 1'b0;
        step(3);
        check("R4 output pin ignored", irq_pend[2], 1'b0);
        pin_in[6] = 1'b1; step(3); pin_dir[6] = 1'b0;
        step();

        // R11: last pin of group 2 merges into source 2
        pin_in[7] = 1'b0;
        step(3);
        check("R11 merged edge", irq_pend[2], 1'b1);
        pin_in[7] = 1'b1; step(3);
        pulse_ack(4'b0100);
        check("R9 ack source 2", irq_pend[2], 1'b0);

        // R6: rising-only on source 1 (mode 01)
        wr_cfg(2'b11, 10'h0A6);
        pin_in[3] = 1'b0;
        step(3);
        check("R6 rise mode ignores fall", irq_pend[1], 1'b0);
        pin_in[3] = 1'b1;
        step(3);
        check("R6 rise mode catches rise", irq_pend[1], 1'b1);
        pulse_ack(4'b0010);

        // R7 + R9 priority: source 3 fall+low
        wr_cfg(2'b11, 10'h026);
        pin_in[8] = 1'b0;
        step(2);
        check("R7 low level pending at k+1", irq_pend[3], 1'b1);
        pulse_ack(4'b1000);                   // meets the edge: ack wins
        check("R7 level survives ack", irq_pend[3], 1'b1);
        pin_in[8] = 1'b1;
        step(2);
        check("R9 ack beat simultaneous edge", irq_pend[3], 1'b0);

        // R8: polarity on source 0 gives rise+high
        wr_cfg(2'b11, 10'h124);
        check("R8 high level pending", irq_pend[0], 1'b1);
        pin_in[2:0] = 3'b000;
        step(2);
        check("R8 no fall/low sense", irq_pend[0], 1'b0);
        wr_cfg(2'b11, 10'h324);
        pin_in[8] = 1'b0;
        step(2);
        check("R8 polarity ignored on source 3", irq_pend[3], 1'b1);
        pin_in[8] = 1'b1;
        step(3);
        pulse_ack(4'b1000);

        // R10: same-value write keeps, changing write clears
        pin_in[4] = 1'b0;
        step(3);
        check("R10 setup pending", irq_pend[2], 1'b1);
        wr_cfg(2'b11, 10'h324);
        check("R10 unchanged write keeps", irq_pend[2], 1'b1);
        wr_cfg(2'b10, 10'h334);
        check("R10 locked write keeps", irq_pend[2], 1'b1);
        wr_cfg(2'b11, 10'h334);
        check("R10 changed write clears", irq_pend[2], 1'b0);

        // R6: both edges on source 2 (mode 11)
        pin_in[4] = 1'b1;
        step(3);
        check("R6 both mode rise", irq_pend[2], 1'b1);
        pulse_ack(4'b0100);
        check("R6 both mode acked", irq_pend[2], 1'b0);
        pin_in[4] = 1'b0;
        step(3);
        check("R6 both mode fall", irq_pend[2], 1'b1);

        // random phase against the model
        for (int c = 0; c < 4000; c++) begin
            check("RAND pend vs model", irq_pend, model_pend());
            check("RAND cfg vs model", cfg_rdata, m_cfg);
            pin_in ^= NPIN'($urandom & $urandom & $urandom);
            if ($urandom_range(31) == 0) pin_dir = NPIN'($urandom & $urandom);
            if ($urandom_range(31) == 0) pin_opt = NPIN'($urandom | $urandom);
            irq_ack = 4'($urandom & $urandom & $urandom);
            cfg_wr = ($urandom_range(15) == 0);
            cpu_lvl = ($urandom_range(3) == 0) ? 2'($urandom) : 2'b11;
            cfg_wdata = 10'($urandom);
            step();
        end
        cfg_wr = 1'b0; irq_ack = '0;
        finish_run();
    end

endmodule